// File: doc/BRIEF.md
# Exception Escalation and Shutdown Sequencer

This block follows what happens when delivering an exception itself goes wrong. A fault raised while the core is running starts a first-level delivery. If that delivery fails, a double fault (vector 8) is delivered next. If the double fault delivery also fails, the block issues a one-cycle shutdown bus request with its own cycle-type code. It then stays halted until reset. When a delivery completes cleanly, the escalation level drops back to zero.

The block also holds the access-rights word of the global descriptor table's cache entry. After reset that word has the present, system, LDT-type value. When a selector is validated against the table while that word says "not present", the result is a general-protection fault (vector 13), not a not-present fault. If such a failed validation happens while an exception is being delivered, it counts as a delivery failure and pushes the escalation one level further.

States: IDLE (level 0), FIRST (delivering the first exception, level 1), DOUBLE (delivering vector 8, level 2), SHUT (the single shutdown request cycle, level 3) and HALT (level 3, terminal). Transitions:
- IDLE→FIRST on a raised fault or a failed validation.
- FIRST→IDLE and DOUBLE→IDLE on a clean completion.
- FIRST→DOUBLE and DOUBLE→SHUT on a delivery failure.
- SHUT→HALT unconditionally.
- HALT→HALT until reset.

Top module: `fault_escalator`

## Requirements
- R1: After reset, `esc_level` is 0 and `deliver_valid`, `shutdown_req`, `halted` and `bus_cyc_code` are all 0.
- R2: In IDLE, a `fault_raise` pulse makes `deliver_valid` 1, `deliver_vec` equal to the `fault_vec` sampled with it, and `esc_level` 1 from the next cycle on.
- R3: While delivering, `deliver_done` with no delivery failure in the same cycle returns to IDLE: `esc_level` 0 and `deliver_valid` 0 on the next cycle.
- R4: A delivery failure at level 1 moves to level 2 with `deliver_vec` = 8 on the next cycle.
- R5: A delivery failure at level 2 gives, on the next cycle, `shutdown_req` = 1, `bus_cyc_code` = 2'b10, `deliver_valid` = 0 and `esc_level` = 3.
- R6: Once halted, every fault, completion, validation and load input is ignored: `halted` stays 1, `esc_level` stays 3, and no delivery or shutdown is requested. Only reset leaves HALT.
- R7: The descriptor-cache access-rights word resets to 0x82. Bit 7 of that word is the present flag. A validation while bit 7 is 1 raises no fault.
- R8: In IDLE, `sel_check` while bit 7 of the stored word is 0 starts a delivery with vector 13. This takes priority over a `fault_raise` in the same cycle.
- R9: During a delivery, `sel_check` against a not-present word counts as a delivery failure, the same as `deliver_fault`.
- R10: When `deliver_fault` and `deliver_done` arrive in the same cycle, the failure wins.
- R11: `fault_raise` during a delivery, with no delivery failure, changes neither the vector nor the level.
- R12: `shutdown_req` is never high on two consecutive cycles. It is followed by `halted` = 1. `bus_cyc_code` is nonzero only while `shutdown_req` is high.
- R13: `ar_load` writes `ar_wdata` into the stored access-rights word, and the next validation uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_raise | input | 1 | Fault raised by the core (strobe) |
| fault_vec | input | 8 | Vector of the raised fault |
| deliver_done | input | 1 | Current delivery finished (strobe) |
| deliver_fault | input | 1 | Current delivery itself faulted (strobe) |
| sel_check | input | 1 | A selector is validated against the descriptor table |
| ar_load | input | 1 | Write strobe for the stored access-rights word |
| ar_wdata | input | 32 | New access-rights word |
| deliver_valid | output | 1 | An exception is being delivered |
| deliver_vec | output | 8 | Vector to deliver, 0 when idle |
| esc_level | output | 2 | Escalation level 0..3 |
| shutdown_req | output | 1 | One-cycle shutdown bus request |
| bus_cyc_code | output | 2 | Bus cycle type: 2'b10 shutdown, 2'b00 otherwise |
| halted | output | 1 | Terminal halt until reset |

## Verification
The properties assume that strobes are single-cycle and synchronous to the clock. They also assume that `deliver_done` and `deliver_fault` are only meaningful while a delivery is outstanding, although the design tolerates them at other times. Each property samples the present flag through the internal validation result, so no property has to predict what a write of the access-rights word does. The stimulus changes inputs only on falling edges and holds each strobe for exactly one cycle. It issues completions only while a delivery is visible, and it loads the access-rights word only at level 0. The final halt phase deliberately drives every input at once to exercise R6.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_DOUBLE,
        ST_SHUT,
        ST_HALT
    } fe_state_e;

    localparam int unsigned VEC_W = 8;

    localparam logic [VEC_W-1:0] VEC_GP = VEC_W'(13);
    localparam logic [VEC_W-1:0] VEC_DF = VEC_W'(8);

    localparam logic [1:0] CYC_NONE = 2'b00;
    localparam logic [1:0] CYC_SHUT = 2'b10;

endpackage

// File: rtl/fe_ar_cache.sv
module fe_ar_cache #(
    parameter int unsigned AR_W = 32,
    parameter int unsigned PRES_BIT = 7,
    parameter logic [AR_W-1:0] AR_RESET = AR_W'(32'h82)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AR_W-1:0] wdata,
    output logic            present
);

    logic [AR_W-1:0] ar_q;
    logic            ar_rest_unused;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q <= AR_RESET;
        end else if (load) begin
            ar_q <= wdata;
        end
    end

    assign present = ar_q[PRES_BIT];

    generate
        if (PRES_BIT == 0) begin : g_low
            assign ar_rest_unused = ^ar_q[AR_W-1:1];
        end else if (PRES_BIT == AR_W - 1) begin : g_high
            assign ar_rest_unused = ^ar_q[AR_W-2:0];
        end else begin : g_mid
            assign ar_rest_unused = ^{ar_q[AR_W-1:PRES_BIT+1], ar_q[PRES_BIT-1:0]};
        end
    endgenerate

endmodule

// File: rtl/fe_seq_fsm.sv
module fe_seq_fsm
    import fe_pkg::*;
#(
    parameter int unsigned VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raise,
    input  logic [VW-1:0] raise_vec,
    input  logic          gp_hit,
    input  logic          done,
    input  logic          fail,
    output fe_state_e     state,
    output logic [VW-1:0] vec_q
);

    fe_state_e     state_n;
    logic [VW-1:0] vec_n;

    always_comb begin
        state_n = state;
        vec_n   = vec_q;
        unique case (state)
            ST_IDLE: begin
                if (gp_hit) begin
                    state_n = ST_FIRST;
                    vec_n   = VW'(VEC_GP);
                end else if (raise) begin
                    state_n = ST_FIRST;
                    vec_n   = raise_vec;
                end
            end
            ST_FIRST: begin
                if (fail) begin
                    state_n = ST_DOUBLE;
                    vec_n   = VW'(VEC_DF);
                end else if (done) begin
                    state_n = ST_IDLE;
                end
            end
            ST_DOUBLE: begin
                if (fail) begin
                    state_n = ST_SHUT;
                end else if (done) begin
                    state_n = ST_IDLE;
                end
            end
            ST_SHUT: begin
                state_n = ST_HALT;
            end
            ST_HALT: begin
                state_n = ST_HALT;
            end
            default: begin
                state_n = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            vec_q <= '0;
        end else begin
            state <= state_n;
            vec_q <= vec_n;
        end
    end

endmodule

// File: rtl/fe_out_map.sv
module fe_out_map
    import fe_pkg::*;
#(
    parameter int unsigned VW = VEC_W
) (
    input  fe_state_e     state,
    input  logic [VW-1:0] vec_q,
    output logic          deliver_valid,
    output logic [VW-1:0] deliver_vec,
    output logic [1:0]    esc_level,
    output logic          shutdown_req,
    output logic [1:0]    bus_cyc_code,
    output logic          halted
);

    always_comb begin
        deliver_valid = 1'b0;
        deliver_vec   = '0;
        esc_level     = 2'd0;
        shutdown_req  = 1'b0;
        bus_cyc_code  = CYC_NONE;
        halted        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                esc_level = 2'd0;
            end
            ST_FIRST: begin
                deliver_valid = 1'b1;
                deliver_vec   = vec_q;
                esc_level     = 2'd1;
            end
            ST_DOUBLE: begin
                deliver_valid = 1'b1;
                deliver_vec   = vec_q;
                esc_level     = 2'd2;
            end
            ST_SHUT: begin
                esc_level    = 2'd3;
                shutdown_req = 1'b1;
                bus_cyc_code = CYC_SHUT;
            end
            ST_HALT: begin
                esc_level = 2'd3;
                halted    = 1'b1;
            end
            default: begin
                esc_level = 2'd3;
                halted    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
    import fe_pkg::*;
#(
    parameter int unsigned VW       = VEC_W,
    parameter int unsigned AR_W     = 32,
    parameter int unsigned PRES_BIT = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_raise,
    input  logic [VW-1:0]   fault_vec,
    input  logic            deliver_done,
    input  logic            deliver_fault,
    input  logic            sel_check,
    input  logic            ar_load,
    input  logic [AR_W-1:0] ar_wdata,
    output logic            deliver_valid,
    output logic [VW-1:0]   deliver_vec,
    output logic [1:0]      esc_level,
    output logic            shutdown_req,
    output logic [1:0]      bus_cyc_code,
    output logic            halted
);

    fe_state_e     state;
    logic [VW-1:0] vec_q;
    logic          gdt_present;
    logic          gp_hit;
    logic          fail_any;
    logic          ar_we;

    // Loads are frozen once the sequencer has reached its terminal state.
    assign ar_we = ar_load && (state != ST_SHUT) && (state != ST_HALT);

    fe_ar_cache #(
        .AR_W     (AR_W),
        .PRES_BIT (PRES_BIT),
        .AR_RESET (AR_W'(32'h82))
    ) u_ar (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ar_we),
        .wdata   (ar_wdata),
        .present (gdt_present)
    );

    assign gp_hit   = sel_check && !gdt_present;
    assign fail_any = deliver_fault || gp_hit;

    fe_seq_fsm #(.VW(VW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise     (fault_raise),
        .raise_vec (fault_vec),
        .gp_hit    (gp_hit),
        .done      (deliver_done),
        .fail      (fail_any),
        .state     (state),
        .vec_q     (vec_q)
    );

    fe_out_map #(.VW(VW)) u_out (
        .state         (state),
        .vec_q         (vec_q),
        .deliver_valid (deliver_valid),
        .deliver_vec   (deliver_vec),
        .esc_level     (esc_level),
        .shutdown_req  (shutdown_req),
        .bus_cyc_code  (bus_cyc_code),
        .halted        (halted)
    );

endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int unsigned VW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fault_raise,
    input logic          deliver_done,
    input logic          deliver_fault,
    input logic          sel_check,
    input logic          gdt_present,
    input logic          deliver_valid,
    input logic [VW-1:0] deliver_vec,
    input logic [1:0]    esc_level,
    input logic          shutdown_req,
    input logic [1:0]    bus_cyc_code,
    input logic          halted
);

    a_r2_raise_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_level == 2'd0 && fault_raise) |=> (deliver_valid && esc_level == 2'd1));

    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid && deliver_done && !deliver_fault && !(sel_check && !gdt_present))
        |=> (esc_level == 2'd0 && !deliver_valid));

    a_r4_double_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_level == 2'd1 && deliver_fault) |=> (esc_level == 2'd2 && deliver_vec == VW'(8)));

    a_r5_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_level == 2'd2 && deliver_fault) |=> (shutdown_req && bus_cyc_code == 2'b10 && !deliver_valid));

    a_r6_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !shutdown_req && !deliver_valid));

    a_r8_gp_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_level == 2'd0 && sel_check && !gdt_present) |=> (deliver_vec == VW'(13)));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> (!shutdown_req && halted));

    a_r12_code_only_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_code != 2'b00) == shutdown_req);

endmodule

bind fault_escalator fe_checker #(.VW(VW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_raise   (fault_raise),
    .deliver_done  (deliver_done),
    .deliver_fault (deliver_fault),
    .sel_check     (sel_check),
    .gdt_present   (gdt_present),
    .deliver_valid (deliver_valid),
    .deliver_vec   (deliver_vec),
    .esc_level     (esc_level),
    .shutdown_req  (shutdown_req),
    .bus_cyc_code  (bus_cyc_code),
    .halted        (halted)
);

// File: tb/fault_escalator_tb_top.sv
module fault_escalator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_raise = 1'b0;
    logic [7:0]  fault_vec = '0;
    logic        deliver_done = 1'b0;
    logic        deliver_fault = 1'b0;
    logic        sel_check = 1'b0;
    logic        ar_load = 1'b0;
    logic [31:0] ar_wdata = '0;
    logic        deliver_valid;
    logic [7:0]  deliver_vec;
    logic [1:0]  esc_level;
    logic        shutdown_req;
    logic [1:0]  bus_cyc_code;
    logic        halted;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    fault_escalator dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_raise   (fault_raise),
        .fault_vec     (fault_vec),
        .deliver_done  (deliver_done),
        .deliver_fault (deliver_fault),
        .sel_check     (sel_check),
        .ar_load       (ar_load),
        .ar_wdata      (ar_wdata),
        .deliver_valid (deliver_valid),
        .deliver_vec   (deliver_vec),
        .esc_level     (esc_level),
        .shutdown_req  (shutdown_req),
        .bus_cyc_code  (bus_cyc_code),
        .halted        (halted)
    );

    // entry: raise, vec[7:0], done, dfault, selchk | exp valid, vec[7:0], lvl[1:0], shut
    localparam int NSTEP = 11;
    localparam logic [23:0] STEPS [NSTEP] = '{
        {1'b1, 8'h0E, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0E, 2'd1, 1'b0}, // R2
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0}, // R3
        {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 2'd1, 1'b0}, // R2
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 2'd2, 1'b0}, // R4
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0}, // R3
        {1'b1, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06, 2'd1, 1'b0}, // R2
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h08, 2'd2, 1'b0}, // R10
        {1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 8'h08, 2'd2, 1'b0}, // R11
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08, 2'd2, 1'b0}, // R7
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0}, // R3
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 1'b0}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic [7:0] v, input logic d,
                         input logic f, input logic s);
        fault_raise   = r;
        fault_vec     = v;
        deliver_done  = d;
        deliver_fault = f;
        sel_check     = s;
        @(negedge clk);
        fault_raise   = 1'b0;
        deliver_done  = 1'b0;
        deliver_fault = 1'b0;
        sel_check     = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic v, input logic [7:0] vec,
                              input logic [1:0] lvl, input logic sh, input logic hl);
        chk({req, " valid"}, 32'(deliver_valid), 32'(v));
        chk({req, " vec"}, 32'(deliver_vec), 32'(vec));
        chk({req, " level"}, 32'(esc_level), 32'(lvl));
        chk({req, " shutdown"}, 32'(shutdown_req), 32'(sh));
        chk({req, " code"}, 32'(bus_cyc_code), sh ? 32'h2 : 32'h0);
        chk({req, " halted"}, 32'(halted), 32'(hl));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        expect_out("R1", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        for (int i = 0; i < NSTEP; i++) begin
            drive(STEPS[i][23], STEPS[i][22:15], STEPS[i][14], STEPS[i][13], STEPS[i][12]);
            expect_out($sformatf("table step %0d", i), STEPS[i][11], STEPS[i][10:3],
                       STEPS[i][2:1], STEPS[i][0], 1'b0);
        end

        // R13: clear the present bit of the access-rights word
        ar_load  = 1'b1;
        ar_wdata = 32'h0000_0002;
        @(negedge clk);
        ar_load = 1'b0;
        expect_out("R13 load", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R8: failed validation beats a simultaneous raise
        drive(1'b1, 8'h05, 1'b0, 1'b0, 1'b1);
        expect_out("R8 R13", 1'b1, 8'd13, 2'd1, 1'b0, 1'b0);

        // R9: failed validation during delivery escalates
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_out("R9", 1'b1, 8'd8, 2'd2, 1'b0, 1'b0);

        // R5: second failure gives the shutdown pulse
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_out("R5", 1'b0, 8'h00, 2'd3, 1'b1, 1'b0);

        // R12: the pulse lasts one cycle and is followed by halt
        @(negedge clk);
        expect_out("R12", 1'b0, 8'h00, 2'd3, 1'b0, 1'b1);

        // R6: everything ignored while halted, including a load
        ar_load  = 1'b1;
        ar_wdata = 32'h0000_0082;
        drive(1'b1, 8'h03, 1'b1, 1'b1, 1'b1);
        ar_load = 1'b0;
        expect_out("R6", 1'b0, 8'h00, 2'd3, 1'b0, 1'b1);
        drive(1'b1, 8'h21, 1'b0, 1'b0, 1'b0);
        expect_out("R6 again", 1'b0, 8'h00, 2'd3, 1'b0, 1'b1);

        // R6/R1: reset releases the halt
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R6 reset", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: access-rights word back to 0x82, validation passes
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_out("R7 reset value", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0);

        // R2 after reset: normal delivery still works
        drive(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
        expect_out("R2 post reset", 1'b1, 8'hFF, 2'd1, 1'b0, 1'b0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule